// File: doc/BRIEF.md
# Book-Paged I2C Register Target

This block is an I2C target that opens a large byte-register space to a controller on a two-wire bus. The space has three levels. A book holds pages, and a page holds 128 byte registers. The current book and the current page are kept in two in-band registers. The offset 0x00 on every page selects the page. The offset 0x7F on page 0 of each book selects the book. Every other access reaches backing storage at the triple (book, page, offset).

The controller writes a sub-address byte after the address byte. It then streams data bytes or, after a repeated START, reads bytes back. The sub-address advances after every byte and wraps inside the page. The book and page pointers survive STOP conditions, so the controller sets them once and then works inside that page. The storage side is a plain port: book, page, offset, write data, a one-cycle write strobe and a combinational read-data input. SCL is only observed, because the target never stretches the clock.

Top module: `bpi2c_target`

## Requirements
- R1: A byte after START whose upper seven bits equal the parameter `TGT_ADDR` (default 0x2C) is acknowledged, and bit 0 selects read (1) or write (0). Any other address gets no acknowledge. The target then ignores the bus, including later data bytes, until the next START.
- R2: In a write, the first byte after the address loads the 7-bit sub-address (bit 7 ignored). Each later data byte is acknowledged and stored at the sub-address with one single-cycle `mem_we` pulse. The sub-address then increments.
- R3: Writing offset 0x00 on any page sets the current page to the full 8-bit value (0 to 255). It does not strobe storage.
- R4: Writing offset 0x7F while the current page is 0 sets the current book and clears the page to 0, without strobing storage. On any other page, offset 0x7F is an ordinary storage byte.
- R5: The book and page pointers keep their values across STOP and START until they are rewritten, and they address all storage traffic.
- R6: A random read (sub-address write, repeated START, address with read bit) returns the byte at the sub-address, MSB first. The target changes SDA only while SCL is low, and it releases SDA once the controller answers a byte with NACK.
- R7: A sequential read returns successive offsets while the controller acknowledges. Offsets wrap from 0x7F to 0x00 inside the page.
- R8: Reading offset 0x00 returns the current page. Reading offset 0x7F on page 0 returns the current book.
- R9: A START or STOP that arrives before the eighth bit of a data byte aborts that byte. Nothing is written to storage or to the pointers.
- R10: After reset the book and page are 0 and SDA is released. SDA is also released after every STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| mem_book | output | BOOK_W | Current book for the storage access |
| mem_page | output | PAGE_W | Current page for the storage access |
| mem_off | output | 7 | Current register offset |
| mem_wdata | output | 8 | Byte to store |
| mem_we | output | 1 | One-cycle store strobe |
| mem_rdata | input | 8 | Byte stored at (mem_book, mem_page, mem_off), combinational |

## Verification
The assertions assume that SCL stays in each level for many system clocks. This lets the target's SDA updates, which happen a few cycles after a synchronized SCL fall, be checked against the raw SCL level. They also assume that the controller never makes a START or STOP while the target drives SDA. The bench controller model keeps every quarter bit at ten clocks. It raises START and STOP only while it owns SDA, and it aborts only inside bytes it writes itself.

// File: rtl/bpi2c_pkg.sv
package bpi2c_pkg;
  localparam int DATA_W = 8;
  localparam int OFF_W  = 7;
  localparam int BITS_W = 4;
  localparam logic [OFF_W-1:0] OFF_PAGE_SEL = '0;
  localparam logic [OFF_W-1:0] OFF_BOOK_SEL = '1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } bp_state_e;
endpackage

// File: rtl/bpi2c_line_sync.sv
module bpi2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_s, scl_p, sda_p;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_ff[SYNC_STAGES-1];
  assign sda_s = sda_ff[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/bpi2c_bank_regs.sv
module bpi2c_bank_regs
  import bpi2c_pkg::*;
#(
  parameter int BOOK_W = 8,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic [BOOK_W-1:0] book,
  output logic [PAGE_W-1:0] page,
  output logic              is_reg,
  output logic [DATA_W-1:0] reg_rdata
);
  logic hit_page, hit_book;

  assign hit_page  = (off == OFF_PAGE_SEL);
  assign hit_book  = (off == OFF_BOOK_SEL) && (page == '0);
  assign is_reg    = hit_page | hit_book;
  assign reg_rdata = hit_page ? DATA_W'(page) : DATA_W'(book);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      book <= '0;
      page <= '0;
    end else if (wr_en) begin
      if (hit_page) begin
        page <= PAGE_W'(wdata);
      end else if (hit_book) begin
        book <= BOOK_W'(wdata);
        page <= '0;
      end
    end
  end
endmodule

// File: rtl/bpi2c_target.sv
module bpi2c_target
  import bpi2c_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR    = 7'h2C,
  parameter int         BOOK_W      = 8,
  parameter int         PAGE_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [BOOK_W-1:0] mem_book,
  output logic [PAGE_W-1:0] mem_page,
  output logic [OFF_W-1:0]  mem_off,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam logic [BITS_W-1:0] RX_LAST = BITS_W'(DATA_W);
  localparam logic [BITS_W-1:0] TX_LAST = BITS_W'(DATA_W - 1);

  logic [1:0] rst_ff;
  logic       rst_sync_n;
  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;

  bp_state_e          st, st_n, after, after_n;
  logic [BITS_W-1:0]  cnt, cnt_n;
  logic [DATA_W-1:0]  shr, shr_n;
  logic [OFF_W-1:0]   sub, sub_n;
  logic               mack, mack_n;
  logic               commit, is_reg;
  logic [DATA_W-1:0]  reg_rdata, rd_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_sync_n = rst_ff[1];

  bpi2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  bpi2c_bank_regs #(.BOOK_W(BOOK_W), .PAGE_W(PAGE_W)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(commit), .off(sub),
    .wdata(shr), .book(mem_book), .page(mem_page),
    .is_reg(is_reg), .reg_rdata(reg_rdata)
  );

  assign rd_byte = is_reg ? reg_rdata : mem_rdata;

  always_comb begin
    st_n    = st;
    after_n = after;
    cnt_n   = cnt;
    shr_n   = shr;
    sub_n   = sub;
    mack_n  = mack;
    commit  = 1'b0;
    if (stop_det) begin
      st_n = ST_IDLE;
    end else if (start_det) begin
      st_n  = ST_ADDR;
      cnt_n = '0;
    end else begin
      unique case (st)
        ST_ADDR, ST_SUB, ST_WDATA: begin
          if (scl_rise && cnt != RX_LAST) begin
            shr_n = {shr[DATA_W-2:0], sda_s};
            cnt_n = cnt + 1'b1;
          end
          if (scl_fall && cnt == RX_LAST) begin
            st_n = ST_ACK;
            if (st == ST_ADDR) begin
              if (shr[DATA_W-1:1] == TGT_ADDR) after_n = shr[0] ? ST_RDATA : ST_SUB;
              else                             st_n    = ST_IDLE;
            end else if (st == ST_SUB) begin
              sub_n   = shr[OFF_W-1:0];
              after_n = ST_WDATA;
            end else begin
              commit  = 1'b1;
              sub_n   = sub + 1'b1;
              after_n = ST_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            st_n  = after;
            cnt_n = '0;
            if (after == ST_RDATA) shr_n = rd_byte;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt == TX_LAST) begin
              st_n  = ST_RACK;
              sub_n = sub + 1'b1;
              cnt_n = '0;
            end else begin
              shr_n = {shr[DATA_W-2:0], 1'b0};
              cnt_n = cnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_n = ~sda_s;
          if (scl_fall) begin
            if (mack) begin
              st_n  = ST_RDATA;
              shr_n = rd_byte;
              cnt_n = '0;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st    <= ST_IDLE;
      after <= ST_IDLE;
      cnt   <= '0;
      shr   <= '0;
      sub   <= '0;
      mack  <= 1'b0;
    end else begin
      st    <= st_n;
      after <= after_n;
      cnt   <= cnt_n;
      shr   <= shr_n;
      sub   <= sub_n;
      mack  <= mack_n;
    end
  end

  assign sda_oe    = (st == ST_ACK) || (st == ST_RDATA && !shr[DATA_W-1]);
  assign mem_off   = sub;
  assign mem_wdata = shr;
  assign mem_we    = commit & ~is_reg;
endmodule

// File: rtl/bpi2c_target_chk.sv
module bpi2c_target_chk
  import bpi2c_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              start_det,
  input logic              stop_det,
  input logic              sda_oe,
  input logic              mem_we,
  input logic [OFF_W-1:0]  mem_off,
  input logic [PAGE_W-1:0] mem_page
);
  assert_sda_moves_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  assert_page_sel_not_stored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_off != OFF_PAGE_SEL);

  assert_book_sel_not_stored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !(mem_off == OFF_BOOK_SEL && mem_page == '0));

  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  assert_abort_no_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> !mem_we);

  assert_release_after_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
endmodule

bind bpi2c_target bpi2c_target_chk #(.PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .mem_we(mem_we),
  .mem_off(mem_off), .mem_page(mem_page)
);

// File: tb/sim_bpi2c_target.sv
`timescale 1ns/1ps
module sim_bpi2c_target;
  localparam logic [6:0] ADDR = 7'h2C;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, m_scl_low, m_sda_low;
  logic sda_oe, mem_we;
  logic [7:0] mem_book, mem_page, mem_wdata, mem_rdata;
  logic [6:0] mem_off;
  wire scl_bus = !m_scl_low;
  wire sda_bus = !(m_sda_low || sda_oe);

  bpi2c_target #(.TGT_ADDR(ADDR)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .sda_oe(sda_oe), .mem_book(mem_book), .mem_page(mem_page),
    .mem_off(mem_off), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata)
  );

  logic [7:0] store [0:2047];
  logic [7:0] expm  [0:2047];
  logic [7:0] eb, ep;
  int vectors = 0, miscompares = 0, wcnt = 0;
  bit done = 0;

  assign mem_rdata = store[{mem_book[1:0], mem_page[1:0], mem_off}];
  always @(posedge clk) if (mem_we) begin
    store[{mem_book[1:0], mem_page[1:0], mem_off}] <= mem_wdata;
    wcnt <= wcnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic wq(); repeat (Q) @(posedge clk); #1; endtask

  task automatic i2c_start();
    m_sda_low = 0; m_scl_low = 0; wq();
    m_sda_low = 1; wq();
    m_scl_low = 1; wq();
  endtask
  task automatic i2c_rstart();
    m_sda_low = 0; wq(); m_scl_low = 0; wq();
    m_sda_low = 1; wq(); m_scl_low = 1; wq();
  endtask
  task automatic i2c_stop();
    m_sda_low = 1; wq(); m_scl_low = 0; wq();
    m_sda_low = 0; wq();
  endtask
  task automatic send_bit(input bit b);
    m_sda_low = !b; wq(); m_scl_low = 0; wq(); wq(); m_scl_low = 1; wq();
  endtask
  task automatic recv_bit(output bit b);
    m_sda_low = 0; wq(); m_scl_low = 0; wq(); b = sda_bus; wq(); m_scl_low = 1; wq();
  endtask
  task automatic wbyte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b); ack = !b;
  endtask
  task automatic rbyte(output logic [7:0] d, input bit give_ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
    send_bit(!give_ack);
  endtask

  function automatic int ix(input logic [7:0] b, input logic [7:0] p, input logic [6:0] o);
    return {b[1:0], p[1:0], o};
  endfunction
  function automatic logic [7:0] model_rd(input logic [6:0] o);
    if (o == 7'h00) return ep;
    if (o == 7'h7F && ep == 8'h00) return eb;
    return expm[ix(eb, ep, o)];
  endfunction
  task automatic model_wr(input logic [6:0] o, input logic [7:0] d);
    if (o == 7'h00) ep = d;
    else if (o == 7'h7F && ep == 8'h00) begin eb = d; ep = 8'h00; end
    else expm[ix(eb, ep, o)] = d;
  endtask

  task automatic do_write(input logic [6:0] off, input int n, input logic [31:0] bytes, input string tag);
    bit a; logic [6:0] o = off;
    i2c_start();
    wbyte({ADDR, 1'b0}, a); chk(a, {tag, " addr ack R1"}, a, 1);
    wbyte({1'b0, off}, a);  chk(a, {tag, " sub ack R2"}, a, 1);
    for (int k = 0; k < n; k++) begin
      wbyte(bytes[8*k +: 8], a); chk(a, {tag, " data ack R2"}, a, 1);
      model_wr(o, bytes[8*k +: 8]); o = o + 7'd1;
    end
    i2c_stop();
  endtask

  task automatic do_read(input logic [6:0] off, input int n, input string tag);
    bit a; logic [7:0] d; logic [6:0] o = off;
    i2c_start();
    wbyte({ADDR, 1'b0}, a);
    wbyte({1'b0, off}, a);
    i2c_rstart();
    wbyte({ADDR, 1'b1}, a); chk(a, {tag, " read addr ack R1"}, a, 1);
    for (int k = 0; k < n; k++) begin
      rbyte(d, k < n - 1);
      chk(d == model_rd(o), tag, d, model_rd(o));
      o = o + 7'd1;
    end
    chk(sda_oe == 1'b0, "R6 release after NACK", sda_oe, 0);
    i2c_stop();
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R10 sda released in reset", sda_oe, 0);
    do_read(7'h00, 1, "R10 page zero after reset");
    do_read(7'h7F, 1, "R10 book zero after reset");
  endtask

  task automatic t_mismatch();
    bit a; int w0 = wcnt;
    i2c_start();
    wbyte({7'h2D, 1'b0}, a); chk(!a, "R1 wrong address not acked", a, 0);
    wbyte(8'h10, a);         chk(!a, "R1 ignored sub byte", a, 0);
    wbyte(8'h55, a);         chk(!a, "R1 ignored data byte", a, 0);
    i2c_stop();
    chk(wcnt == w0, "R1 no store on mismatch", wcnt, w0);
    do_read(7'h10, 1, "R1 storage untouched");
  endtask

  task automatic t_book_page();
    do_write(7'h00, 1, 32'h02, "R3 set page");
    do_read(7'h00, 1, "R8 page readback");
    do_write(7'h00, 1, 32'h00, "R3 page 0");
    do_write(7'h7F, 1, 32'h03, "R4 set book");
    do_read(7'h7F, 1, "R8 book readback");
    do_write(7'h00, 1, 32'h02, "R3 page 2");
    do_write(7'h7F, 1, 32'h01, "R4 book via 7F on page 2 is ordinary");
    do_read(7'h7F, 1, "R4 ordinary 7F data");
    do_write(7'h00, 1, 32'h00, "R3 back to page 0");
    do_read(7'h7F, 1, "R4 book unchanged by page-2 write");
    do_write(7'h00, 1, 32'h01, "R3 page 1");
    do_write(7'h00, 1, 32'h00, "R3 page 0");
    do_write(7'h7F, 1, 32'h02, "R4 book write");
    do_read(7'h00, 1, "R4 page cleared by book write");
  endtask

  task automatic t_full_page();
    int w0 = wcnt;
    do_write(7'h00, 1, 32'hFF, "R3 page 255");
    do_read(7'h00, 1, "R3 full page value");
    chk(wcnt == w0, "R3 no store on page select", wcnt, w0);
    do_write(7'h00, 1, 32'h01, "R3 restore page");
  endtask

  task automatic t_seq();
    do_write(7'h20, 1, 32'hA5, "R2 single write");
    do_read(7'h20, 1, "R6 random read");
    do_write(7'h40, 4, 32'h13_5A_C3_7E, "R2 sequential write");
    do_read(7'h40, 4, "R7 sequential read");
    do_read(7'h3F, 3, "R7 read across written block");
  endtask

  task automatic t_wrap();
    do_write(7'h00, 1, 32'h03, "R3 page 3");
    do_write(7'h7E, 1, 32'h6B, "R2 write near end");
    do_read(7'h7E, 4, "R7 wrap 7F to 00 returns page");
  endtask

  task automatic t_persist();
    do_write(7'h00, 1, 32'h00, "R3 page 0");
    do_write(7'h7F, 1, 32'h01, "R4 book 1");
    do_write(7'h00, 1, 32'h02, "R3 page 2");
    do_write(7'h33, 1, 32'h11, "R5 write book1 page2");
    do_write(7'h00, 1, 32'h00, "R3 page 0");
    do_write(7'h7F, 1, 32'h02, "R4 book 2");
    do_write(7'h00, 1, 32'h02, "R3 page 2");
    do_write(7'h33, 1, 32'h22, "R5 write book2 page2");
    do_read(7'h33, 1, "R5 book2 data after stops");
    do_read(7'h00, 1, "R5 page persists");
    do_write(7'h00, 1, 32'h00, "R3 page 0");
    do_write(7'h7F, 1, 32'h01, "R4 book 1");
    do_write(7'h00, 1, 32'h02, "R3 page 2");
    do_read(7'h33, 1, "R5 book1 data kept");
  endtask

  task automatic t_abort();
    bit a; int w0;
    do_write(7'h00, 1, 32'h01, "R3 page 1");
    w0 = wcnt;
    i2c_start();
    wbyte({ADDR, 1'b0}, a);
    wbyte(8'h30, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    i2c_stop();
    chk(wcnt == w0, "R9 stop mid-byte no store", wcnt, w0);
    i2c_start();
    wbyte({ADDR, 1'b0}, a);
    wbyte(8'h00, a);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    i2c_rstart();
    wbyte({ADDR, 1'b0}, a);
    chk(a, "R9 address after abort acked", a, 1);
    i2c_stop();
    chk(wcnt == w0, "R9 start mid-byte no store", wcnt, w0);
    do_read(7'h30, 1, "R9 data unchanged");
    do_read(7'h00, 1, "R9 page unchanged");
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) begin
      store[i] = 8'(i * 37 + 5);
      expm[i]  = 8'(i * 37 + 5);
    end
    eb = 8'h00; ep = 8'h00;
    m_scl_low = 0; m_sda_low = 0;
    rst_n = 0;
    repeat (5) @(posedge clk); #1;
    t_reset_pre();
    rst_n = 1;
    repeat (5) @(posedge clk); #1;
    t_reset();
    t_mismatch();
    t_book_page();
    t_full_page();
    t_seq();
    t_wrap();
    t_persist();
    t_abort();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  task automatic t_reset_pre();
    chk(sda_oe == 1'b0, "R10 sda released while reset held", sda_oe, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule